// File: doc/BRIEF.md
# Strided and Fragmented Read Address Walker

This block turns the transfer fields of one accepted descriptor into a series of memory read requests. Each request carries a byte address and a byte length. It is offered on a valid/ready handshake to the read engine that sits downstream. The walker latches all of its fields when `start` is seen in the idle state. It then issues requests until the transfer is covered, and marks the end with a one-cycle `done` pulse. A failure reported by the read engine on `rd_err` cuts the walk short and raises a data-error pulse instead.

There are two walking modes. In line mode (`mode` = 0) the block reads one line per request, starting at fragment address 0. After each request the address moves forward by a programmable stride. In fragment mode (`mode` = 1) the block visits up to five fragment addresses in order. Each request ends at the next 4 KiB page boundary. Every fragment address is built from a 32-bit low word, with a 12-bit extension word placed above it as bits [43:32].

The controller has four states. IDLE waits for `start`. ISSUE presents one request at a time. FINISH drives `done` for one cycle. FAULT drives one of the two error pulses for one cycle. The transitions are:
- IDLE goes to ISSUE on a start with work to do.
- IDLE goes to FINISH on a start with zero size.
- IDLE goes to FAULT on a start in line mode with a zero line size.
- ISSUE goes to FINISH when the last request is accepted.
- ISSUE goes to FAULT on `rd_err`.
- FINISH and FAULT both return to IDLE after one cycle.

Top module: `rwalk_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `req_valid`, `done`, `data_err` and `cfg_err` are all 0.
- R2: In line mode, request i has address A0 + i*S, taken modulo 2^44. A0 is `{frag_ext[11:0], frag_lo[31:0]}`. S is `size_stride[31:18]` times 16.
- R3: In line mode, each request length is the smaller of the line size (`size_stride[17:0]`) and the bytes still remaining. The walk ends once the remaining count reaches zero.
- R4: In fragment mode, request k is sent to fragment k. Its address is `{frag_ext[12k+11:12k], frag_lo[32k+31:32k]}`, and fragments are visited in order 0 to 4.
- R5: In fragment mode, each request length is the smaller of 4096 minus address[11:0] and the bytes still remaining. No request crosses a 4 KiB boundary.
- R6: In fragment mode, the walk ends after the fifth request even when bytes remain. It also ends earlier, as soon as the remaining count reaches zero.
- R7: A start with `xfer_size` = 0 issues no request. It pulses `done` in the cycle after the start edge.
- R8: A start in line mode with a zero line size and a nonzero `xfer_size` issues no request. It pulses `cfg_err` in the cycle after the start edge and gives no `done`.
- R9: When `rd_err` is high during a cycle in which a request is presented, that request is not accepted and no further request follows. `data_err` pulses in the next cycle, and no `done` is given.
- R10: While `req_valid` is high and `req_ready` is low, address and length are held unchanged into the next cycle.
- R11: `done` is a single-cycle pulse. It appears in the cycle right after the final handshake. Afterwards all outputs return to 0.
- R12: A `start` pulse, or any change of the descriptor inputs, during a walk has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with the current descriptor fields (used in idle only) |
| mode | input | 1 | 0 = line mode, 1 = fragment mode |
| xfer_size | input | 32 | Total bytes to transfer |
| size_stride | input | 32 | [17:0] line size in bytes, [31:18] stride in 16-byte units |
| frag_lo | input | 160 | Five 32-bit fragment low words, fragment k in bits [32k+31:32k] |
| frag_ext | input | 60 | Five 12-bit upper-address words, fragment k in bits [12k+11:12k] |
| req_valid | output | 1 | A read request is presented |
| req_ready | input | 1 | Read engine accepts the presented request |
| req_addr | output | 44 | Request byte address |
| req_len | output | 32 | Request byte length |
| rd_err | input | 1 | Read failure; ends the walk |
| done | output | 1 | One-cycle pulse at successful completion |
| data_err | output | 1 | One-cycle pulse after a read failure |
| cfg_err | output | 1 | One-cycle pulse for a zero line size in line mode |

## Verification
Every result has a fixed latency:
- The first request, the zero-size `done` and the zero-line `cfg_err` appear one cycle after the start edge.
- Each following request appears one cycle after the previous handshake edge.
- `done` appears one cycle after the final handshake.
- `data_err` appears one cycle after the edge where `rd_err` was sampled.

The bench drives inputs and samples outputs on the falling edge. It therefore checks every outcome at exactly the falling edge that follows the rising edge where that result was registered. Any cycle in a walk that shows neither a request nor an end pulse is counted as a failure. Random `req_ready` stalls exercise the hold rule.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2,
        ST_FAULT  = 2'd3
    } walk_state_t;

    typedef enum logic {
        MODE_LINES = 1'b0,
        MODE_FRAGS = 1'b1
    } walk_mode_t;

endpackage

// File: rtl/rwalk_frag_mux.sv
module rwalk_frag_mux #(
    parameter int N_FRAG = 5,
    parameter int LO_W   = 32,
    parameter int EXT_W  = 12,
    parameter int IDX_W  = 3
) (
    input  logic [N_FRAG*LO_W-1:0]  lo_flat,
    input  logic [N_FRAG*EXT_W-1:0] ext_flat,
    input  logic [IDX_W-1:0]        idx,
    output logic [LO_W+EXT_W-1:0]   addr
);
    localparam int ADDR_W = LO_W + EXT_W;

    logic [ADDR_W-1:0] cand [N_FRAG];

    for (genvar g = 0; g < N_FRAG; g++) begin : g_cand
        assign cand[g] = {ext_flat[g*EXT_W +: EXT_W], lo_flat[g*LO_W +: LO_W]};
    end

    always_comb begin
        addr = cand[0];
        for (int i = 0; i < N_FRAG; i++) begin
            if (idx == IDX_W'(i)) addr = cand[i];
        end
    end
endmodule

// File: rtl/rwalk_len_calc.sv
module rwalk_len_calc
    import rwalk_pkg::*;
#(
    parameter int SIZE_W = 32,
    parameter int LINE_W = 18,
    parameter int PAGE_W = 12
) (
    input  walk_mode_t        mode,
    input  logic [PAGE_W-1:0] page_off,
    input  logic [LINE_W-1:0] line,
    input  logic [SIZE_W-1:0] remaining,
    output logic [SIZE_W-1:0] len
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [SIZE_W-1:0] chunk;

    always_comb begin
        if (mode == MODE_FRAGS) chunk = SIZE_W'(PAGE_BYTES) - SIZE_W'(page_off);
        else                    chunk = SIZE_W'(line);
        len = (chunk < remaining) ? chunk : remaining;
    end
endmodule

// File: rtl/rwalk_gen.sv
module rwalk_gen
    import rwalk_pkg::*;
#(
    parameter int N_FRAG       = 5,
    parameter int LO_W         = 32,
    parameter int EXT_W        = 12,
    parameter int SIZE_W       = 32,
    parameter int LINE_W       = 18,
    parameter int PAGE_W       = 12,
    parameter int STRIDE_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      mode,
    input  logic [SIZE_W-1:0]         xfer_size,
    input  logic [SIZE_W-1:0]         size_stride,
    input  logic [N_FRAG*LO_W-1:0]    frag_lo,
    input  logic [N_FRAG*EXT_W-1:0]   frag_ext,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [LO_W+EXT_W-1:0]     req_addr,
    output logic [SIZE_W-1:0]         req_len,
    input  logic                      rd_err,
    output logic                      done,
    output logic                      data_err,
    output logic                      cfg_err
);
    localparam int ADDR_W   = LO_W + EXT_W;
    localparam int IDX_W    = $clog2(N_FRAG);
    localparam int STRIDE_W = SIZE_W - LINE_W;

    walk_state_t              state_q, state_d;
    walk_mode_t               mode_q;
    logic [SIZE_W-1:0]        rem_q;
    logic [LINE_W-1:0]        line_q;
    logic [ADDR_W-1:0]        stride_q;
    logic [ADDR_W-1:0]        addr_q;
    logic [IDX_W-1:0]         idx_q;
    logic [N_FRAG*LO_W-1:0]   lo_q;
    logic [N_FRAG*EXT_W-1:0]  ext_q;
    logic                     fault_cfg_q;

    logic [SIZE_W-1:0]        len_w;
    logic [SIZE_W-1:0]        rem_after;
    logic [ADDR_W-1:0]        next_frag_addr;
    logic [IDX_W-1:0]         idx_next;
    logic                     last_frag;
    logic                     bad_line;

    assign idx_next  = idx_q + IDX_W'(1);
    assign last_frag = (idx_q == IDX_W'(N_FRAG - 1));
    assign rem_after = rem_q - len_w;
    assign bad_line  = (walk_mode_t'(mode) == MODE_LINES) && (size_stride[LINE_W-1:0] == '0);

    rwalk_frag_mux #(
        .N_FRAG (N_FRAG),
        .LO_W   (LO_W),
        .EXT_W  (EXT_W),
        .IDX_W  (IDX_W)
    ) u_mux (
        .lo_flat  (lo_q),
        .ext_flat (ext_q),
        .idx      (idx_next),
        .addr     (next_frag_addr)
    );

    rwalk_len_calc #(
        .SIZE_W (SIZE_W),
        .LINE_W (LINE_W),
        .PAGE_W (PAGE_W)
    ) u_len (
        .mode      (mode_q),
        .page_off  (addr_q[PAGE_W-1:0]),
        .line      (line_q),
        .remaining (rem_q),
        .len       (len_w)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (xfer_size == '0)  state_d = ST_FINISH;
                    else if (bad_line)    state_d = ST_FAULT;
                    else                  state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (rd_err) begin
                    state_d = ST_FAULT;
                end else if (req_ready &&
                             ((rem_after == '0) || ((mode_q == MODE_FRAGS) && last_frag))) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_LINES;
            rem_q       <= '0;
            line_q      <= '0;
            stride_q    <= '0;
            addr_q      <= '0;
            idx_q       <= '0;
            lo_q        <= '0;
            ext_q       <= '0;
            fault_cfg_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                mode_q      <= walk_mode_t'(mode);
                rem_q       <= xfer_size;
                line_q      <= size_stride[LINE_W-1:0];
                stride_q    <= ADDR_W'(size_stride[SIZE_W-1 -: STRIDE_W]) << STRIDE_SHIFT;
                addr_q      <= {frag_ext[EXT_W-1:0], frag_lo[LO_W-1:0]};
                idx_q       <= '0;
                lo_q        <= frag_lo;
                ext_q       <= frag_ext;
                fault_cfg_q <= 1'b1;
            end else if (state_q == ST_ISSUE) begin
                if (rd_err) begin
                    fault_cfg_q <= 1'b0;
                end else if (req_ready) begin
                    rem_q  <= rem_after;
                    idx_q  <= idx_next;
                    addr_q <= (mode_q == MODE_FRAGS) ? next_frag_addr : addr_q + stride_q;
                end
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_valid = (state_q == ST_ISSUE);
        req_addr  = addr_q;
        req_len   = len_w;
        done      = (state_q == ST_FINISH);
        data_err  = (state_q == ST_FAULT) && !fault_cfg_q;
        cfg_err   = (state_q == ST_FAULT) && fault_cfg_q;
    end

    // Request held while stalled (R10)
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !rd_err |=> req_valid && $stable(req_addr) && $stable(req_len));

    // Never a zero-length request, never past the remaining count (R3)
    a_r3_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (req_len <= rem_q));

    // Fragment requests stay inside one page (R5)
    a_r5_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (mode_q == MODE_FRAGS) |->
            (SIZE_W'(req_addr[PAGE_W-1:0]) + req_len) <= SIZE_W'(1 << PAGE_W));

    // Read error ends the walk with a data-error pulse (R9)
    a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rd_err |=> data_err && !req_valid);

    // Zero size finishes at once (R7)
    a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && start && (xfer_size == '0) |=> done);

    // Single-cycle end pulses (R11)
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !req_valid);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid, done, data_err, cfg_err}));

endmodule

// File: tb/rwalk_gen_tb_top.sv
`timescale 1ns/1ps
module rwalk_gen_tb_top;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [31:0]   xfer_size = '0;
    logic [31:0]   size_stride = '0;
    logic [159:0]  frag_lo = '0;
    logic [59:0]   frag_ext = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [43:0]   req_addr;
    logic [31:0]   req_len;
    logic          rd_err = 1'b0;
    logic          done;
    logic          data_err;
    logic          cfg_err;

    int n_checks = 0;
    int n_errors = 0;

    logic [43:0] e_addr[$];
    logic [31:0] e_len[$];
    int          e_kind;   // 0 done, 1 cfg error

    always #2 clk = ~clk;  // 250 MHz

    rwalk_gen dut_i (
        .clk, .rst_n, .start, .mode, .xfer_size, .size_stride,
        .frag_lo, .frag_ext, .req_valid, .req_ready, .req_addr, .req_len,
        .rd_err, .done, .data_err, .cfg_err
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [43:0] frag_addr(input int k);
        return {frag_ext[k*12 +: 12], frag_lo[k*32 +: 32]};
    endfunction

    function automatic void build_expect();
        logic [31:0] rem;
        logic [31:0] line;
        logic [31:0] chunk;
        logic [31:0] l;
        logic [43:0] a;
        logic [43:0] stride;
        e_addr.delete();
        e_len.delete();
        e_kind = 0;
        rem    = xfer_size;
        line   = {14'd0, size_stride[17:0]};
        stride = {26'd0, size_stride[31:18], 4'd0};
        if (rem == 0) return;
        if (mode == 1'b0) begin
            if (line == 0) begin
                e_kind = 1;
                return;
            end
            a = frag_addr(0);
            while (rem != 0) begin
                l = (line < rem) ? line : rem;
                e_addr.push_back(a);
                e_len.push_back(l);
                rem = rem - l;
                a   = a + stride;
            end
        end else begin
            for (int k = 0; k < 5 && rem != 0; k++) begin
                a     = frag_addr(k);
                chunk = 32'd4096 - {20'd0, a[11:0]};
                l     = (chunk < rem) ? chunk : rem;
                e_addr.push_back(a);
                e_len.push_back(l);
                rem = rem - l;
            end
        end
    endfunction

    task automatic set_frag(input int k, input logic [31:0] lo, input logic [11:0] ext);
        frag_lo[k*32 +: 32] = lo;
        frag_ext[k*12 +: 12] = ext;
    endtask

    task automatic rand_frags();
        for (int k = 0; k < 5; k++) set_frag(k, $urandom, 12'($urandom));
    endtask

    // err_at: request index that sees rd_err (-1 none); disturb: pulse start mid-walk
    task automatic run_case(input int err_at, input bit disturb);
        int  idx;
        int  cyc;
        bit  fin;
        bit  prev_acc;
        bit  was_valid;
        bit  rdy;
        bit  er;
        bit  disturbed;
        string rq_a;
        string rq_l;
        build_expect();
        rq_a = mode ? "R4" : "R2";
        rq_l = mode ? "R5" : "R3";
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 0; cyc = 0; fin = 0; prev_acc = 1; disturbed = 0;
        while (!fin) begin
            was_valid = 0; rdy = 0; er = 0;
            if (cyc > 4000) begin
                check(0, "R11", "watchdog expired", 64'(cyc), 0);
                fin = 1;
            end else if (data_err) begin
                check(err_at >= 0 && idx == err_at, "R9", "data_err at request index",
                      64'(idx), 64'(err_at));
                fin = 1;
            end else if (cfg_err) begin
                check(e_kind == 1 && idx == 0 && cyc == 0, "R8", "cfg_err timing/kind",
                      64'(cyc), 0);
                fin = 1;
            end else if (done) begin
                if (xfer_size == 0)
                    check(cyc == 0, "R7", "zero-size done latency", 64'(cyc), 0);
                check(e_kind == 0 && err_at < 0, "R11", "done outcome", 64'(e_kind), 0);
                if (mode)
                    check(idx == e_addr.size(), "R6", "fragment request count",
                          64'(idx), 64'(e_addr.size()));
                else
                    check(idx == e_addr.size(), "R3", "line request count",
                          64'(idx), 64'(e_addr.size()));
                check(prev_acc, "R11", "done right after final handshake", 64'(prev_acc), 1);
                fin = 1;
            end else if (req_valid) begin
                was_valid = 1;
                if (idx >= e_addr.size()) begin
                    check(0, mode ? "R6" : "R3", "extra request", 64'(idx), 64'(e_addr.size()));
                    fin = 1;
                end else begin
                    check(req_addr == e_addr[idx], rq_a, "request address", req_addr, e_addr[idx]);
                    check(req_len == e_len[idx], rq_l, "request length", req_len, e_len[idx]);
                    rdy = ($urandom % 4) != 0;
                    er  = (idx == err_at);
                    if (disturb && idx == 1 && !disturbed) begin
                        // R12: new start with scrambled fields while walking
                        disturbed   = 1;
                        start       = 1'b1;
                        mode        = ~mode;
                        xfer_size   = $urandom;
                        size_stride = $urandom;
                        rand_frags();
                    end
                    req_ready = rdy;
                    rd_err    = er;
                end
            end else begin
                check(0, "R10", "idle cycle inside walk", 0, 1);
                fin = 1;
            end
            if (!fin) begin
                @(negedge clk);
                prev_acc = was_valid && rdy && !er;
                if (prev_acc) idx++;
                start = 1'b0; req_ready = 1'b0; rd_err = 1'b0;
                cyc++;
            end
        end
        if (disturb)
            check(disturbed, "R12", "disturbance applied", 64'(disturbed), 1);
        @(negedge clk);
        check(!done && !data_err && !cfg_err && !req_valid, "R11", "outputs quiet after end",
              {60'd0, done, data_err, cfg_err, req_valid}, 0);
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        check(!req_valid && !done && !data_err && !cfg_err, "R1", "outputs in reset",
              {60'd0, req_valid, done, data_err, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && !done && !data_err && !cfg_err, "R1", "outputs after reset",
              {60'd0, req_valid, done, data_err, cfg_err}, 0);

        // Line mode: 100-byte lines, stride 10*16, trimmed tail (R2, R3)
        mode = 0; xfer_size = 350; size_stride = {14'd10, 18'd100};
        set_frag(0, 32'hFFFF_FF80, 12'hABC);
        run_case(-1, 0);

        // Fragment mode: offsets, ext bits, trimmed last (R4, R5)
        mode = 1; xfer_size = 5000;
        set_frag(0, 32'h0000_0F00, 12'h001);
        set_frag(1, 32'h0001_0000, 12'h7FF);
        set_frag(2, 32'h0002_0010, 12'h000);
        set_frag(3, 32'h0, 12'h0); set_frag(4, 32'h0, 12'h0);
        run_case(-1, 0);

        // Fragment mode: bytes remain after five fragments (R6)
        mode = 1; xfer_size = 100000; rand_frags();
        set_frag(3, 32'h1234_5FFF, 12'h055);  // one-byte fragment
        run_case(-1, 0);

        // Zero size, both modes (R7)
        mode = 0; xfer_size = 0; size_stride = 32'd0; run_case(-1, 0);
        mode = 1; xfer_size = 0; run_case(-1, 0);

        // Zero line size in line mode (R8)
        mode = 0; xfer_size = 10; size_stride = {14'd3, 18'd0}; run_case(-1, 0);

        // Read error mid-walk (R9)
        mode = 0; xfer_size = 1000; size_stride = {14'd20, 18'd64}; rand_frags();
        run_case(2, 0);
        mode = 1; xfer_size = 20000; rand_frags(); run_case(0, 0);

        // Start and field changes during a walk (R12)
        mode = 0; xfer_size = 640; size_stride = {14'd100, 18'd64}; rand_frags();
        run_case(-1, 1);
        mode = 1; xfer_size = 9000; rand_frags(); run_case(-1, 1);

        // Constrained random mix
        for (int n = 0; n < 40; n++) begin
            int lsz;
            int ea;
            mode = 1'($urandom);
            rand_frags();
            if (mode == 0) begin
                lsz         = 1 + ($urandom % 2000);
                size_stride = {14'($urandom), 18'(lsz)};
                xfer_size   = $urandom % (lsz * 30);
            end else begin
                size_stride = $urandom;
                xfer_size   = $urandom % 25000;
            end
            build_expect();
            ea = (($urandom % 5) == 0 && e_addr.size() > 0) ? int'($urandom % e_addr.size()) : -1;
            run_case(ea, ($urandom % 6) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule